// File: doc/BRIEF.md
# Vertical Clock Group Freeze Controller

This block sits between a vertical transfer pattern generator and the eight vertical clock pins of a frame-transfer image sensor. The eight clock lanes form two groups of four. Each group can be stopped partway through a line while the other group keeps toggling. This lets preview readout move the image and storage sections at different rates. When a group is stopped, its lanes keep the level they last showed. They are not pulled to a fixed value.

For each group, software writes an enable bit, a stop pixel position and a restart pixel position into a shadow register. The block copies the shadow registers into its working copy on each line strobe, so a window never changes inside a line. A window that is enabled applies on every line until software writes a new one. Each cycle the block compares the external horizontal pixel counter with the working positions and registers the gated lanes.

Top module: `vclk_freeze_ctrl`

## Requirements
- R1: Lanes 0 to 3 form group 0 and lanes 4 to 7 form group 1. Each group follows only its own window, so one group can be held while the other tracks the pattern.
- R2: The output is registered. In any cycle where a group's window is disabled, the group's lanes show the input pattern one clock later. After reset all lanes read 0 and both windows are disabled.
- R3: When a group's window is enabled and the pixel count equals its stop position in a cycle without a line strobe, the group's lanes do not change at the following edge.
- R4: While a group is held, its lanes keep the level they had at the stop point, whatever that level is, and ignore the input pattern.
- R5: When the restart position is greater than the stop position, the group follows the pattern again from the cycle where the pixel count equals the restart position. The lanes show that cycle's pattern one clock later.
- R6: When the restart position is less than or equal to the stop position, the group stays held for the rest of the line. A line strobe always releases both groups, and the strobe cycle's pattern appears one clock later.
- R7: An enabled window applies again on every following line, with no new write needed.
- R8: A configuration write takes effect only at the next line strobe. A write made in the same cycle as a strobe waits for the strobe after that.
- R9: A write with `cfg_grp` = 0 updates the shadow registers of group 0 and `cfg_grp` = 1 updates those of group 1. The other group's shadow registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| pix_cnt | input | 12 | Horizontal pixel counter, 0 in the strobe cycle |
| vpat_in | input | 8 | Vertical clock pattern from the generator |
| cfg_wr | input | 1 | Shadow register write strobe |
| cfg_grp | input | 1 | Group selected by the write |
| cfg_en | input | 1 | Window enable written |
| cfg_freeze | input | 12 | Stop pixel position written |
| cfg_resume | input | 12 | Restart pixel position written |
| vclk_out | output | 8 | Gated vertical clock lanes |

## Verification
Assertions check four rules on every cycle: lanes stay stable at a stop hit, lanes pass the pattern through when disabled and after a strobe, a restart follows a valid restart hit, and the working configuration does not change between strobes. Some behaviour spans several lines, so only the bench's scenarios show it. This covers the held level across a whole window, how the two groups interact, windows that recur line after line, inverted and equal positions, and writes that land in a strobe cycle. The bench runs a model of the requirements next to the block and compares every lane on every cycle, across directed cases and random windows.

// File: rtl/vfz_pkg.sv
package vfz_pkg;
    parameter int unsigned VFZ_PIX_W = 12;

    typedef struct packed {
        logic                 en;
        logic [VFZ_PIX_W-1:0] frz;
        logic [VFZ_PIX_W-1:0] res;
    } grp_cfg_t;
endpackage

// File: rtl/vfz_cfg_regs.sv
module vfz_cfg_regs
    import vfz_pkg::*;
#(
    parameter int unsigned NUM_GRP = 2,
    localparam int unsigned GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_strobe_i,
    input  logic                          wr_i,
    input  logic [GSEL_W-1:0]             grp_i,
    input  grp_cfg_t                      wdata_i,
    output grp_cfg_t [NUM_GRP-1:0]        act_o
);
    typedef struct packed {
        grp_cfg_t [NUM_GRP-1:0] shadow;
        grp_cfg_t [NUM_GRP-1:0] act;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // working copy takes the shadow as it stood before this cycle's write
        if (line_strobe_i) begin
            st_d.act = st_q.shadow;
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (wr_i && (grp_i == GSEL_W'(g))) begin
                st_d.shadow[g] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;

    p_midline_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe_i |=> $stable(act_o))
        else $error("working configuration changed without a line strobe");
endmodule

// File: rtl/vfz_group_gate.sv
module vfz_group_gate
    import vfz_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_strobe_i,
    input  logic [VFZ_PIX_W-1:0] pix_i,
    input  logic [LANES-1:0]     pat_i,
    input  grp_cfg_t             cfg_i,
    output logic [LANES-1:0]     out_o
);
    typedef struct packed {
        logic [LANES-1:0] lanes;
        logic             held;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        hit_frz, hit_res, hold;

    always_comb begin
        hit_frz = (pix_i == cfg_i.frz);
        hit_res = (pix_i == cfg_i.res) && (cfg_i.res > cfg_i.frz);
        st_d    = st_q;
        if (line_strobe_i || !cfg_i.en) begin
            hold = 1'b0;
        end else if (hit_frz) begin
            hold = 1'b1;
        end else if (st_q.held && hit_res) begin
            hold = 1'b0;
        end else begin
            hold = st_q.held;
        end
        st_d.held  = hold;
        st_d.lanes = hold ? st_q.lanes : pat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.lanes;

    p_pass_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> out_o == $past(pat_i))
        else $error("disabled group did not follow the pattern");

    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && !line_strobe_i && (pix_i == cfg_i.frz)) |=> $stable(out_o))
        else $error("group changed at its stop position");

    p_resume_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && !line_strobe_i && (pix_i == cfg_i.res) && (cfg_i.res > cfg_i.frz))
        |=> out_o == $past(pat_i))
        else $error("group did not restart at its restart position");

    p_strobe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_strobe_i |=> out_o == $past(pat_i))
        else $error("line strobe did not release the group");
endmodule

// File: rtl/vclk_freeze_ctrl.sv
module vclk_freeze_ctrl
    import vfz_pkg::*;
#(
    parameter int unsigned NUM_GRP = 2,
    parameter int unsigned LANES   = 4,
    localparam int unsigned GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int unsigned OUT_W  = NUM_GRP * LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_strobe,
    input  logic [VFZ_PIX_W-1:0] pix_cnt,
    input  logic [OUT_W-1:0]     vpat_in,
    input  logic                 cfg_wr,
    input  logic [GSEL_W-1:0]    cfg_grp,
    input  logic                 cfg_en,
    input  logic [VFZ_PIX_W-1:0] cfg_freeze,
    input  logic [VFZ_PIX_W-1:0] cfg_resume,
    output logic [OUT_W-1:0]     vclk_out
);
    grp_cfg_t                 wdata;
    grp_cfg_t [NUM_GRP-1:0]   act;

    assign wdata = '{en: cfg_en, frz: cfg_freeze, res: cfg_resume};

    vfz_cfg_regs #(.NUM_GRP(NUM_GRP)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_strobe_i(line_strobe),
        .wr_i         (cfg_wr),
        .grp_i        (cfg_grp),
        .wdata_i      (wdata),
        .act_o        (act)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        vfz_group_gate #(.LANES(LANES)) u_gate (
            .clk          (clk),
            .rst_n        (rst_n),
            .line_strobe_i(line_strobe),
            .pix_i        (pix_cnt),
            .pat_i        (vpat_in[g*LANES +: LANES]),
            .cfg_i        (act[g]),
            .out_o        (vclk_out[g*LANES +: LANES])
        );
    end
endmodule

// File: tb/vclk_freeze_ctrl_test.sv
module vclk_freeze_ctrl_test;
    localparam int LINE_LEN = 32;
    localparam int MAX_CYC  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_strobe = 1'b0;
    logic [11:0] pix_cnt = '0;
    logic [7:0]  vpat_in = '0;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_grp = '0;
    logic        cfg_en = 1'b0;
    logic [11:0] cfg_freeze = '0;
    logic [11:0] cfg_resume = '0;
    logic [7:0]  vclk_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R2";

    // reference state built from the requirements
    logic        sh_en [2], ac_en [2], held [2];
    logic [11:0] sh_f [2], sh_r [2], ac_f [2], ac_r [2];
    logic [7:0]  exp_out;

    // pending write, applied on the next driven cycle
    logic        wr_req = 1'b0;
    logic        wr_grp;
    logic        wr_en;
    logic [11:0] wr_f, wr_r;

    always #5 clk = ~clk;

    vclk_freeze_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .pix_cnt(pix_cnt),
        .vpat_in(vpat_in), .cfg_wr(cfg_wr), .cfg_grp(cfg_grp), .cfg_en(cfg_en),
        .cfg_freeze(cfg_freeze), .cfg_resume(cfg_resume), .vclk_out(vclk_out)
    );

    function automatic logic next_hold(logic stb, logic en, logic [11:0] p,
                                       logic [11:0] f, logic [11:0] r, logic h);
        if (stb || !en) return 1'b0;
        if (p == f) return 1'b1;
        if (h && p == r && r > f) return 1'b0;
        return h;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                sh_en[g] = 0; ac_en[g] = 0; held[g] = 0;
                sh_f[g] = 0; sh_r[g] = 0; ac_f[g] = 0; ac_r[g] = 0;
            end
            exp_out = '0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                held[g] = next_hold(line_strobe, ac_en[g], pix_cnt, ac_f[g], ac_r[g], held[g]);
                if (!held[g]) exp_out[g*4 +: 4] = vpat_in[g*4 +: 4];
            end
            if (line_strobe) begin
                for (int g = 0; g < 2; g++) begin
                    ac_en[g] = sh_en[g]; ac_f[g] = sh_f[g]; ac_r[g] = sh_r[g];
                end
            end
            if (cfg_wr) begin
                sh_en[cfg_grp] = cfg_en; sh_f[cfg_grp] = cfg_freeze; sh_r[cfg_grp] = cfg_resume;
            end
        end
    end

    task automatic check(string t, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: vclk_out=%h expected=%h at cycle %0d", t, act, exp, cyc);
        end
    endtask

    // compare at the falling edge, then drive the next cycle's inputs
    task automatic tick();
        @(negedge clk);
        cyc++;
        check(tag, vclk_out, exp_out);
        pix_cnt     = (pix_cnt == 12'(LINE_LEN - 1)) ? 12'd0 : pix_cnt + 12'd1;
        line_strobe = (pix_cnt == 12'd0);
        vpat_in     = 8'($urandom);
        cfg_wr      = wr_req;
        if (wr_req) begin
            cfg_grp = wr_grp; cfg_en = wr_en; cfg_freeze = wr_f; cfg_resume = wr_r;
        end
        wr_req = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic post_wr(logic g, logic en, int f, int r);
        wr_req = 1'b1; wr_grp = g; wr_en = en; wr_f = 12'(f); wr_r = 12'(r);
    endtask

    // stop so that the next driven cycle is a line strobe
    task automatic to_line_end();
        while (pix_cnt != 12'(LINE_LEN - 1)) tick();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        pix_cnt = 12'(LINE_LEN - 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        total++;
        if (vclk_out !== 8'h00) begin
            bad++;
            $display("FAIL R2: reset vclk_out=%h expected=00", vclk_out);
        end
        rst_n = 1'b1;
        tag = "R2 pass-through";
        run(2 * LINE_LEN);

        // R8: write mid-line, window must not start before the strobe
        tag = "R8 mid-line write";
        while (pix_cnt != 12'd2) tick();
        post_wr(1'b0, 1'b1, 5, 12);
        run(20);
        to_line_end();
        tag = "R3/R4/R5 group 0 window, R1 group 1 free";
        run(LINE_LEN);
        tag = "R7 repeat window";
        run(2 * LINE_LEN);

        // R6: inverted positions on group 1, R9: group 0 untouched
        tag = "R6/R9 inverted window on group 1";
        post_wr(1'b1, 1'b1, 20, 8);
        run(1);
        to_line_end();
        run(2 * LINE_LEN);

        // R6: equal positions
        tag = "R6 equal positions";
        post_wr(1'b0, 1'b1, 9, 9);
        to_line_end();
        run(2 * LINE_LEN);

        // R8: write landing in a strobe cycle waits one more line
        tag = "R8 write in strobe cycle";
        to_line_end();
        post_wr(1'b0, 1'b1, 3, 25);
        run(2 * LINE_LEN + 4);

        // R2: disable both groups
        tag = "R2 disabled again";
        post_wr(1'b0, 1'b0, 0, 0);
        run(1);
        post_wr(1'b1, 1'b0, 0, 0);
        to_line_end();
        run(LINE_LEN + 2);

        // random windows and write timing
        tag = "R7/R9 random";
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 3) == 0)
                post_wr(1'($urandom), 1'($urandom_range(0, 3) != 0),
                        $urandom_range(0, LINE_LEN + 2), $urandom_range(0, LINE_LEN + 2));
            run($urandom_range(1, 40));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung, actual=%0d cycles expected below %0d", MAX_CYC, MAX_CYC);
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end
endmodule